// File: doc/BRIEF.md
# Host Bus Dual-Mode Readout Interface

This block is the host-side port through which a controller reads the sixteen stored charge results of one event. Commands come in as a function code plus a channel subaddress on a dataway-style bus. Each one is accepted in a single clock, and any read answers one clock later with a 16-bit word and a Q bit. The converter side writes raw channel values while the block is idle and then signals event completion. The front-panel streaming port then has the data first. The host sees the event only after that port reports it has finished.

Reads come in two styles, picked by a control bit. In random access, the subaddress names the channel. In sequential mode, every read returns the next retained channel in ascending order, and the first read that finds nothing left answers with Q=0 and ends the event. The host port has its own word formatting: raw, pedestal-subtracted (saturating at zero), or compacted (subtracted, with zero results suppressed). A look-at-me output flags an event waiting for the host, if the host has enabled it. A test command emits a one-cycle calibration gate pulse.

Top module: `hb_readout_if`

## Requirements
- R1: A read (function 2) returns Q=0 and data 0 unless the event is host-ready. An event becomes host-ready on the clock edge where `fp_done` is seen after `cnv_done`. A read in that same cycle is still refused.
- R2: In random mode (control bit 3 = 0), function 2 with subaddress n returns, one cycle later, `rsp_valid`=1 and a word with n in bits [15:12], bit 11 zero, and the formatted value in bits [10:0]. Q=1 when the channel is retained.
- R3: Control bits [1:0] select the format. 0 gives the raw value. 1 gives raw minus pedestal, forced to 0 when negative. 2 or 3 gives the subtracted value, and a zero result is suppressed: Q=0 and data 0.
- R4: In sequential mode (control bit 3 = 1), each read returns the lowest-numbered retained channel not yet returned in this event, ignoring the subaddress. Once none remain, the next read gives Q=0, ends the event, and drops `lam`.
- R5: `lam` is 1 exactly while an event is host-ready and control bit 2 is set.
- R6: Function 9 at subaddress 0 discards the event, restarts the sequential walk and drops `lam`. A clear wins over a `fp_done` or `cnv_done` in the same cycle.
- R7: Function 25 at subaddress 0 drives `test_gate` high for exactly the next cycle. Function 25 at any other subaddress does not.
- R8: Converter writes (`cnv_we`) are taken only while no event is pending. Writes arriving during front-panel or host readout leave the stored value unchanged.
- R9: Function 16 at subaddress 0 loads the control register from `cmd_wdata[3:0]`. Function 17 at subaddress n loads channel n's pedestal from `cmd_wdata[10:0]`. Reset clears control, pedestals, raw values, `lam`, `test_gate` and the response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv_we | input | 1 | Converter writes one channel value |
| cnv_ch | input | 4 | Channel for the converter write |
| cnv_val | input | 11 | Raw converted value |
| cnv_done | input | 1 | Converter finished the event |
| fp_done | input | 1 | Front-panel port finished its readout |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_f | input | 5 | Function code |
| cmd_a | input | 4 | Subaddress |
| cmd_wdata | input | 11 | Write data for control/pedestal commands |
| rsp_valid | output | 1 | A read was answered this cycle |
| rsp_q | output | 1 | Q response of the read |
| rsp_data | output | 16 | Read word |
| lam | output | 1 | Look-at-me request |
| test_gate | output | 1 | Calibration gate pulse |

## Verification
Two collisions are provoked on purpose. First, a host read is issued in the same cycle that `fp_done` arrives; the answer must still be Q=0, and a later read must succeed. Second, a clear is issued in the same cycle as `fp_done`; afterwards `lam` must stay low and reads must keep refusing, even when `fp_done` comes again. Both collisions are judged through `rsp_q` and `lam`. The expected words are computed from channel-indexed formulas for every format, in both read styles.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  localparam logic [4:0] FC_READ  = 5'd2;
  localparam logic [4:0] FC_CLEAR = 5'd9;
  localparam logic [4:0] FC_CTRL  = 5'd16;
  localparam logic [4:0] FC_PED   = 5'd17;
  localparam logic [4:0] FC_TEST  = 5'd25;

  typedef enum logic [1:0] {EV_EMPTY, EV_FRONT, EV_HOST} ev_state_t;

  typedef struct packed {
    logic       seq;
    logic       lam_en;
    logic [1:0] fmt;
  } ctrl_t;
endpackage

// File: rtl/hb_chan_fmt.sv
module hb_chan_fmt #(
  parameter int DW = 11
) (
  input  logic [DW-1:0] raw,
  input  logic [DW-1:0] ped,
  input  logic [1:0]    fmt,
  output logic [DW-1:0] val,
  output logic          keep
);
  logic [DW:0] diff;

  assign diff = {1'b0, raw} - {1'b0, ped};

  always_comb begin
    if (fmt == 2'd0) val = raw;
    else             val = diff[DW] ? '0 : diff[DW-1:0];
    keep = !(fmt[1] && (val == '0));
  end
endmodule

// File: rtl/hb_first_set.sv
module hb_first_set #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/hb_readout_if.sv
module hb_readout_if
  import hbr_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 11,
  parameter int WW  = 16,
  localparam int AW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnv_we,
  input  logic [AW-1:0] cnv_ch,
  input  logic [DW-1:0] cnv_val,
  input  logic          cnv_done,
  input  logic          fp_done,
  input  logic          cmd_valid,
  input  logic [4:0]    cmd_f,
  input  logic [AW-1:0] cmd_a,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic          rsp_q,
  output logic [WW-1:0] rsp_data,
  output logic          lam,
  output logic          test_gate
);
  ev_state_t               st_q, st_d;
  ctrl_t                   ctrl_q, ctrl_d;
  logic [NCH-1:0][DW-1:0]  raw_q, ped_q, fval;
  logic [NCH-1:0]          keep, taken_q;
  logic                    nx_found, hit;
  logic [AW-1:0]           nx_idx, sel;
  logic                    is_rd, is_clr, is_ctrl, is_ped, is_test;

  assign is_rd   = cmd_valid && (cmd_f == FC_READ);
  assign is_clr  = cmd_valid && (cmd_f == FC_CLEAR) && (cmd_a == '0);
  assign is_ctrl = cmd_valid && (cmd_f == FC_CTRL)  && (cmd_a == '0);
  assign is_ped  = cmd_valid && (cmd_f == FC_PED);
  assign is_test = cmd_valid && (cmd_f == FC_TEST)  && (cmd_a == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    hb_chan_fmt #(.DW(DW)) u_fmt (
      .raw (raw_q[c]),
      .ped (ped_q[c]),
      .fmt (ctrl_q.fmt),
      .val (fval[c]),
      .keep(keep[c])
    );
  end

  hb_first_set #(.N(NCH)) u_next (
    .req  (keep & ~taken_q),
    .found(nx_found),
    .idx  (nx_idx)
  );

  always_comb begin
    sel = ctrl_q.seq ? nx_idx : cmd_a;
    hit = (st_q == EV_HOST) && (ctrl_q.seq ? nx_found : keep[cmd_a]);
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      EV_EMPTY: if (cnv_done) st_d = EV_FRONT;
      EV_FRONT: if (fp_done)  st_d = EV_HOST;
      EV_HOST:  if (is_rd && ctrl_q.seq && !nx_found) st_d = EV_EMPTY;
      default:  st_d = EV_EMPTY;
    endcase
    if (is_clr) st_d = EV_EMPTY;
    ctrl_d = is_ctrl ? ctrl_t'(cmd_wdata[3:0]) : ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= EV_EMPTY;
      ctrl_q    <= '0;
      raw_q     <= '0;
      ped_q     <= '0;
      taken_q   <= '0;
      lam       <= 1'b0;
      test_gate <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_q     <= 1'b0;
      rsp_data  <= '0;
    end else begin
      st_q   <= st_d;
      ctrl_q <= ctrl_d;
      if (cnv_we && st_q == EV_EMPTY) raw_q[cnv_ch] <= cnv_val;
      if (is_ped) ped_q[cmd_a] <= cmd_wdata;
      if (is_clr || (st_q != EV_HOST && st_d == EV_HOST)) taken_q <= '0;
      else if (is_rd && hit && ctrl_q.seq) taken_q[nx_idx] <= 1'b1;
      lam       <= ctrl_d.lam_en && (st_d == EV_HOST);
      test_gate <= is_test;
      rsp_valid <= is_rd;
      rsp_q     <= is_rd && hit;
      rsp_data  <= (is_rd && hit) ? ((WW'(sel) << (WW - AW)) | WW'(fval[sel])) : '0;
    end
  end

  AST_HOST_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    rsp_q |-> ($past(st_q) == EV_HOST));  // R1
  AST_SUPPRESSED_NO_Q: assert property (@(posedge clk) disable iff (rst)
    (rsp_q && $past(ctrl_q.fmt[1])) |-> (rsp_data[DW-1:0] != '0));  // R3
  AST_SEQ_END: assert property (@(posedge clk) disable iff (rst)
    (is_rd && ctrl_q.seq && st_q == EV_HOST && !nx_found) |=> (!rsp_q && st_q == EV_EMPTY && !lam));  // R4
  AST_LAM_NEEDS_HOST: assert property (@(posedge clk) disable iff (rst)
    lam |-> (st_q == EV_HOST));  // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    is_clr |=> (st_q == EV_EMPTY && !lam));  // R6
  AST_TEST_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
    test_gate |-> $past(is_test));  // R7
  AST_RAW_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (st_q != EV_EMPTY) |=> $stable(raw_q));  // R8
endmodule

// File: tb/tb_hb_readout_if.sv
module tb_hb_readout_if;
  logic        clk = 1'b0;
  logic        rst;
  logic        cnv_we, cnv_done, fp_done, cmd_valid;
  logic [3:0]  cnv_ch, cmd_a;
  logic [10:0] cnv_val, cmd_wdata;
  logic [4:0]  cmd_f;
  logic        rsp_valid, rsp_q, lam, test_gate;
  logic [15:0] rsp_data;

  int vecs = 0;
  int bad  = 0;
  int cyc  = 0;

  always #10 clk = ~clk;

  hb_readout_if dut (
    .clk(clk), .rst(rst), .cnv_we(cnv_we), .cnv_ch(cnv_ch), .cnv_val(cnv_val),
    .cnv_done(cnv_done), .fp_done(fp_done), .cmd_valid(cmd_valid), .cmd_f(cmd_f),
    .cmd_a(cmd_a), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_q(rsp_q),
    .rsp_data(rsp_data), .lam(lam), .test_gate(test_gate)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cyc);
      finish_run();
    end
  end

  task automatic check(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int raw_of(int ch, int fm);
    if (ch % 3 == 0) return ch * 64;
    if (ch % 3 == 1) return ch * 64 + 7 + fm * 13;
    return ch * 40;
  endfunction

  function automatic int ped_of(int ch);
    return ch * 64;
  endfunction

  function automatic int fmt_of(int v, int p, int fm);
    if (fm == 0) return v;
    return (v >= p) ? v - p : 0;
  endfunction

  function automatic bit kept(int v, int p, int fm);
    return !(fm >= 2 && fmt_of(v, p, fm) == 0);
  endfunction

  function automatic int word_of(int ch, int val);
    return (ch << 12) | val;
  endfunction

  task automatic idle();
    cnv_we = 0; cnv_done = 0; fp_done = 0; cmd_valid = 0;
    cnv_ch = 0; cnv_val = 0; cmd_f = 0; cmd_a = 0; cmd_wdata = 0;
  endtask

  // one command cycle; fp/cd add same-cycle event strobes
  task automatic cmd(int f, int a, int wd, bit fp = 0, bit cd = 0);
    @(negedge clk);
    cmd_valid = 1; cmd_f = 5'(f); cmd_a = 4'(a); cmd_wdata = 11'(wd);
    fp_done = fp; cnv_done = cd;
    @(negedge clk);
    idle();
  endtask

  task automatic strobe(bit cd, bit fp);
    @(negedge clk);
    cnv_done = cd; fp_done = fp;
    @(negedge clk);
    idle();
  endtask

  task automatic load_event(int fm);
    for (int ch = 0; ch < 16; ch++) begin
      @(negedge clk);
      cnv_we = 1; cnv_ch = 4'(ch); cnv_val = 11'(raw_of(ch, fm));
    end
    @(negedge clk);
    idle();
    strobe(1, 0);
  endtask

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R9 reset rsp_valid", rsp_valid, 0);
    check("R9 reset lam", lam, 0);
    check("R9 reset test_gate", test_gate, 0);

    // pedestals zero after reset: subtract mode returns raw
    cmd(16, 0, 4'b0101);
    @(negedge clk); cnv_we = 1; cnv_ch = 3; cnv_val = 77;
    @(negedge clk); idle();
    strobe(1, 0); strobe(0, 1);
    cmd(2, 3, 0);
    check("R9 reset pedestal zero", rsp_data, word_of(3, 77));
    cmd(9, 0, 0);

    for (int fm = 0; fm < 4; fm++) begin
      automatic int le = (fm != 3);
      cmd(16, 0, (le << 2) | fm);
      for (int ch = 0; ch < 16; ch++) cmd(17, ch, ped_of(ch));
      load_event(fm);
      cmd(2, 5, 0);
      check("R1 read before front done Q", rsp_q, 0);
      check("R1 read before front done data", rsp_data, 0);
      check("R5 lam before host-ready", lam, 0);
      cmd(2, 1, 0, 1);
      check("R1 read same cycle as fp_done Q", rsp_q, 0);
      check("R1 read same cycle valid", rsp_valid, 1);
      check("R5 lam when host-ready", lam, le);
      @(negedge clk); cnv_we = 1; cnv_ch = 0; cnv_val = 1234;
      @(negedge clk); idle();
      for (int ch = 0; ch < 16; ch++) begin
        automatic int v = raw_of(ch, fm);
        automatic int p = ped_of(ch);
        automatic bit k = kept(v, p, fm);
        cmd(2, ch, 0);
        check(ch == 0 ? "R8 write during readout ignored" : "R2 random read Q", rsp_q, k);
        check("R3 random read word", rsp_data, k ? word_of(ch, fmt_of(v, p, fm)) : 0);
      end
      cmd(16, 0, 8 | (le << 2) | fm);
      for (int ch = 0; ch < 16; ch++) begin
        automatic int v = raw_of(ch, fm);
        automatic int p = ped_of(ch);
        if (kept(v, p, fm)) begin
          cmd(2, 15 - ch, 0);
          check("R4 sequential Q", rsp_q, 1);
          check("R4 sequential word", rsp_data, word_of(ch, fmt_of(v, p, fm)));
          check("R5 lam held during walk", lam, le);
        end
      end
      cmd(2, 0, 0);
      check("R4 exhausted Q", rsp_q, 0);
      check("R4 lam dropped at end", lam, 0);
      cmd(2, 0, 0);
      check("R1 read after event ended", rsp_q, 0);
      cmd(16, 0, (le << 2) | fm);
    end

    // clear on a host-ready event
    cmd(16, 0, 4'b0100);
    load_event(0);
    strobe(0, 1);
    check("R5 lam before clear", lam, 1);
    cmd(9, 0, 0);
    check("R6 lam after clear", lam, 0);
    cmd(2, 2, 0);
    check("R6 read after clear", rsp_q, 0);

    // clear collides with fp_done
    load_event(0);
    cmd(9, 0, 0, 1);
    check("R6 clear beats fp_done lam", lam, 0);
    strobe(0, 1);
    cmd(2, 4, 0);
    check("R6 no event after clear+fp_done", rsp_q, 0);
    check("R6 lam stays low", lam, 0);

    // clear with subaddress other than 0 is not a clear
    load_event(0);
    strobe(0, 1);
    cmd(9, 2, 0);
    check("R6 clear needs subaddress 0", lam, 1);
    cmd(9, 0, 0);

    // test gate
    cmd(25, 0, 0);
    check("R7 test pulse", test_gate, 1);
    @(negedge clk);
    check("R7 pulse one cycle", test_gate, 0);
    cmd(25, 3, 0);
    check("R7 no pulse at other subaddress", test_gate, 0);

    finish_run();
  end
endmodule